// File: doc/BRIEF.md
# Programmable Interrupt Controller Command Decoder

This block is the byte-wide register front end of an eight-line programmable interrupt controller. It sits on a two-address bus. Writes to address 0 either start a new initialisation sequence or carry an operation command. Writes to address 1 either continue that sequence or load the interrupt mask. Reads return the pending register, the in-service register, the mask or a poll result. The block holds the mode bits, the vector base and the mask. It drives in-service clears and priority-offset changes into a small rotating priority resolver. That resolver decides whether the interrupt request output is raised.

Request lines are edge-triggered: a rising edge on a line marks it pending. An acknowledge pulse, or a read in poll mode, accepts the winning line. The acknowledge returns a vector equal to the programmed base plus the line number. Level-triggered initialisation is not implemented. Asking for it raises a flag that stays set until the next initialisation word. The design uses an asynchronous active-low reset whose release is expected to be synchronised outside the block.

Top module: `pic_cmd_decoder`

## Requirements
- R1: An address-0 write with bit 4 set is an initialisation word. It clears the pending, in-service and mask registers, the priority offset, the vector base, the read select, poll, special mask, auto end-of-interrupt, rotate-on-auto-EOI and nested mode. It records bit 0 as "mode word follows" and bit 1 as "single unit". It sets `level_unsup` exactly when bit 3 is 1.
- R2: Address-1 writes after an initialisation word are taken in this order: the base word, then a cascade word (only when not single), then a mode word (only when requested). The mode word sets nested mode from bit 4 and auto end-of-interrupt from bit 1. Once the sequence is complete, an address-1 write loads the mask, and an address-1 read returns it.
- R3: The base word supplies vector bits 7:3, with bits 2:0 zero. One cycle after an accepted acknowledge, `vec_out` equals the base plus the winning line.
- R4: A rising edge on `irq_in[n]` sets pending bit n. A line's rank is (n − offset) mod 8, and a lower rank wins. `int_req` is 1 when the best unmasked pending line outranks the best in-service line, or when nothing is in service.
- R5: An acknowledge while `int_req` is 1 clears the winner's pending bit. Without auto end-of-interrupt it also sets the winner's in-service bit. With auto end-of-interrupt it sets no in-service bit, and if rotate-on-auto-EOI is on, the offset becomes winner + 1. An acknowledge while `int_req` is 0 returns base + 7 and changes no state.
- R6: An address-0 command word (bits 4 and 3 clear) with command field bits 7:5 equal to 0 or 4 sets rotate-on-auto-EOI to bit 7.
- R7: Command 1 clears the best-ranked in-service bit. Command 5 does the same and also sets the offset to (cleared line + 1) mod 8.
- R8: Command 3 clears the in-service bit of line bits 2:0. Command 7 does the same and also sets the offset to (that line + 1) mod 8.
- R9: Command 6 sets the offset to (bits 2:0 + 1) mod 8 and leaves the in-service register unchanged.
- R10: Command 1 or 5 with no in-service bit set changes neither the in-service register nor the offset.
- R11: An address-0 word with bit 4 clear and bit 3 set is a read-control word. When its bit 1 is 1, bit 0 selects what an address-0 read returns: 1 gives the in-service register, 0 gives the pending register. When bit 1 is 0, the selection is kept.
- R12: A read-control word with bit 2 set arms poll. The next read returns 0x80 OR the winning line and accepts that line as an acknowledge would; with no request it returns 0x00. Either way the read clears poll.
- R13: A read-control word with bit 6 set loads special mask from bit 5. With special mask on, masked in-service lines do not block lower-ranked requests.
- R14: With nested mode on, an in-service bit on line `NEST_LINE` (default 2) is ignored when the current in-service rank is worked out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 1 | Register address (0 or 1) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rd_en` is high |
| irq_in | input | 8 | Edge-triggered request lines |
| ack | input | 1 | Interrupt acknowledge pulse |
| int_req | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the last acknowledge |
| level_unsup | output | 1 | Level-triggered mode was requested and is unsupported |

## Verification
The hardest state to reach is a rotated priority offset that must be observed. The offset has no read path, so each rotating command is followed by two fresh requests that the old offset and the new offset would order differently. The acknowledged vector then shows which offset is in force. The same pairing shows that an end-of-interrupt on an empty in-service register leaves the offset alone. The rotate-on-auto-EOI flag is exercised the same way, across several acknowledges with auto end-of-interrupt on.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned NLINES = 8;
  localparam int unsigned LW     = $clog2(NLINES);
  localparam int unsigned DW     = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_state_t;

  function automatic logic [NLINES-1:0] line_bit(input logic [LW-1:0] l);
    line_bit = '0;
    line_bit[l] = 1'b1;
  endfunction
endpackage

// File: rtl/pic_resolver.sv
module pic_resolver
  import pic_pkg::*;
(
  input  logic [NLINES-1:0] req,
  input  logic [LW-1:0]     off,
  output logic              found,
  output logic [LW-1:0]     rank
);
  logic [NLINES-1:0] rot;

  // rot[k] holds the line whose rank is k under the current offset
  for (genvar g = 0; g < NLINES; g++) begin : g_rot
    assign rot[g] = req[LW'(g) + off];
  end

  always_comb begin
    found = |rot;
    rank  = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (rot[i]) rank = LW'(i);
    end
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_wr,
  input  logic         data_wr,
  input  logic         f_more,
  input  logic         f_single,
  input  logic         f_level,
  input  logic         f_nested,
  input  logic         f_aeoi,
  input  logic [4:0]   base_in,
  output logic         mask_wr,
  output logic         nested,
  output logic         aeoi,
  output logic         level_flag,
  output logic [4:0]   base_hi
);
  seq_state_t st_q, st_d;
  logic more_q, more_d, single_q, single_d;
  logic nested_d, aeoi_d, level_d;
  logic [4:0] base_d;
  logic upd;

  assign upd = start_wr | data_wr;

  always_comb begin
    st_d     = st_q;
    more_d   = more_q;
    single_d = single_q;
    nested_d = nested;
    aeoi_d   = aeoi;
    level_d  = level_flag;
    base_d   = base_hi;
    if (start_wr) begin
      st_d     = SEQ_BASE;
      more_d   = f_more;
      single_d = f_single;
      level_d  = f_level;
      nested_d = 1'b0;
      aeoi_d   = 1'b0;
      base_d   = '0;
    end else if (data_wr) begin
      unique case (st_q)
        SEQ_BASE: begin
          base_d = base_in;
          if (!single_q)   st_d = SEQ_CASC;
          else if (more_q) st_d = SEQ_MODE;
          else             st_d = SEQ_IDLE;
        end
        SEQ_CASC: st_d = more_q ? SEQ_MODE : SEQ_IDLE;
        SEQ_MODE: begin
          nested_d = f_nested;
          aeoi_d   = f_aeoi;
          st_d     = SEQ_IDLE;
        end
        default: st_d = SEQ_IDLE;
      endcase
    end
  end

  assign mask_wr = data_wr && (st_q == SEQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SEQ_IDLE;
      more_q     <= 1'b0;
      single_q   <= 1'b0;
      nested     <= 1'b0;
      aeoi       <= 1'b0;
      level_flag <= 1'b0;
      base_hi    <= '0;
    end else if (upd) begin
      st_q       <= st_d;
      more_q     <= more_d;
      single_q   <= single_d;
      nested     <= nested_d;
      aeoi       <= aeoi_d;
      level_flag <= level_d;
      base_hi    <= base_d;
    end
  end
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
  import pic_pkg::*;
#(
  parameter int unsigned NEST_LINE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NLINES-1:0] irq_in,
  input  logic              ack,
  output logic              int_req,
  output logic [DW-1:0]     vec_out,
  output logic              level_unsup
);
  localparam logic [LW-1:0] NEST_IDX = LW'(NEST_LINE);
  localparam logic [LW-1:0] SPUR_IDX = '1;

  logic [NLINES-1:0] irr_q, irr_d, isr_q, isr_d, imr_q, imr_d, irq_q;
  logic [LW-1:0]     off_q, off_d;
  logic              rsel_q, rsel_d, poll_q, poll_d, smm_q, smm_d, rot_q, rot_d;
  logic [DW-1:0]     vec_d;

  logic start_wr, ctl_wr, cmd_wr, data_wr, mask_wr;
  logic mode_nested, mode_aeoi;
  logic [4:0] base_hi;
  logic [2:0] cmd;

  assign start_wr = wr_en && !addr && wdata[4];
  assign ctl_wr   = wr_en && !addr && !wdata[4] && wdata[3];
  assign cmd_wr   = wr_en && !addr && !wdata[4] && !wdata[3];
  assign data_wr  = wr_en && addr;
  assign cmd      = wdata[7:5];

  pic_init_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_wr(start_wr), .data_wr(data_wr),
    .f_more(wdata[0]), .f_single(wdata[1]), .f_level(wdata[3]),
    .f_nested(wdata[4]), .f_aeoi(wdata[1]), .base_in(wdata[7:3]),
    .mask_wr(mask_wr), .nested(mode_nested), .aeoi(mode_aeoi),
    .level_flag(level_unsup), .base_hi(base_hi)
  );

  // priority evaluation
  logic [NLINES-1:0] pend_req, cur_req;
  logic              pend_found, cur_found, eoi_found;
  logic [LW-1:0]     pend_rank, cur_rank, eoi_rank, win_line, eoi_line;

  assign pend_req = irr_q & ~imr_q;

  always_comb begin
    cur_req = isr_q;
    if (smm_q)       cur_req = cur_req & ~imr_q;
    if (mode_nested) cur_req = cur_req & ~line_bit(NEST_IDX);
  end

  pic_resolver u_pend (.req(pend_req), .off(off_q), .found(pend_found), .rank(pend_rank));
  pic_resolver u_cur  (.req(cur_req),  .off(off_q), .found(cur_found),  .rank(cur_rank));
  pic_resolver u_eoi  (.req(isr_q),    .off(off_q), .found(eoi_found),  .rank(eoi_rank));

  assign win_line = pend_rank + off_q;
  assign eoi_line = eoi_rank + off_q;
  assign int_req  = pend_found && (!cur_found || (pend_rank < cur_rank));

  // read path
  always_comb begin
    if (poll_q)     rdata = int_req ? {1'b1, {(DW-LW-1){1'b0}}, win_line} : '0;
    else if (!addr) rdata = rsel_q ? isr_q : irr_q;
    else            rdata = imr_q;
  end

  logic take, poll_rd;
  assign poll_rd = rd_en && poll_q;
  assign take    = (ack || poll_rd) && int_req;

  always_comb begin
    irr_d  = irr_q | (irq_in & ~irq_q);
    isr_d  = isr_q;
    imr_d  = imr_q;
    off_d  = off_q;
    rsel_d = rsel_q;
    poll_d = poll_q;
    smm_d  = smm_q;
    rot_d  = rot_q;
    vec_d  = vec_out;

    if (take) begin
      irr_d = irr_d & ~line_bit(win_line);
      if (!mode_aeoi)  isr_d = isr_d | line_bit(win_line);
      else if (rot_q)  off_d = win_line + LW'(1);
    end
    if (ack) vec_d = {base_hi, int_req ? win_line : SPUR_IDX};
    if (poll_rd) poll_d = 1'b0;

    if (start_wr) begin
      irr_d  = '0;
      isr_d  = '0;
      imr_d  = '0;
      off_d  = '0;
      rsel_d = 1'b0;
      poll_d = 1'b0;
      smm_d  = 1'b0;
      rot_d  = 1'b0;
    end else if (ctl_wr) begin
      if (wdata[2]) poll_d = 1'b1;
      if (wdata[1]) rsel_d = wdata[0];
      if (wdata[6]) smm_d  = wdata[5];
    end else if (cmd_wr) begin
      unique case (cmd)
        3'd0, 3'd4: rot_d = cmd[2];
        3'd1, 3'd5: begin
          if (eoi_found) begin
            isr_d = isr_d & ~line_bit(eoi_line);
            if (cmd[2]) off_d = eoi_line + LW'(1);
          end
        end
        3'd3, 3'd7: begin
          isr_d = isr_d & ~line_bit(wdata[LW-1:0]);
          if (cmd[2]) off_d = wdata[LW-1:0] + LW'(1);
        end
        3'd6: off_d = wdata[LW-1:0] + LW'(1);
        default: ;
      endcase
    end else if (mask_wr) begin
      imr_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= '0;
      irr_q   <= '0;
      isr_q   <= '0;
      imr_q   <= '0;
      off_q   <= '0;
      rsel_q  <= 1'b0;
      poll_q  <= 1'b0;
      smm_q   <= 1'b0;
      rot_q   <= 1'b0;
      vec_out <= '0;
    end else begin
      irq_q   <= start_wr ? '0 : irq_in;
      irr_q   <= irr_d;
      isr_q   <= isr_d;
      imr_q   <= imr_d;
      off_q   <= off_d;
      rsel_q  <= rsel_d;
      poll_q  <= poll_d;
      smm_q   <= smm_d;
      rot_q   <= rot_d;
      vec_out <= vec_d;
    end
  end
endmodule

// File: rtl/pic_cmd_chk.sv
module pic_cmd_chk
  import pic_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              addr,
  input logic [DW-1:0]     wdata,
  input logic              ack,
  input logic              int_req,
  input logic              mode_aeoi,
  input logic              level_unsup,
  input logic [NLINES-1:0] irr_q,
  input logic [NLINES-1:0] isr_q,
  input logic [NLINES-1:0] imr_q,
  input logic [LW-1:0]     off_q,
  input logic [LW-1:0]     win_line
);
  // R1
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (isr_q == '0 && imr_q == '0 && off_q == '0 && irr_q == '0));

  // R1
  level_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level_unsup) |-> $past(wr_en && !addr && wdata[4] && wdata[3]));

  // R4
  req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((irr_q & ~imr_q) != '0));

  // R5
  ack_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_req && !mode_aeoi && !(wr_en && !addr)) |=> isr_q[$past(win_line)]);

  // R8
  specific_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[7:5] == 3'd3 && !ack) |=> !isr_q[$past(wdata[2:0])]);

  // R10
  empty_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[6:3] == 4'b0100 && isr_q == '0 && !ack)
      |=> (isr_q == '0 && $stable(off_q)));
endmodule

bind pic_cmd_decoder pic_cmd_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ack(ack), .int_req(int_req), .mode_aeoi(mode_aeoi), .level_unsup(level_unsup),
  .irr_q(irr_q), .isr_q(isr_q), .imr_q(imr_q), .off_q(off_q), .win_line(win_line)
);

// File: tb/test_pic_cmd_decoder.sv
module test_pic_cmd_decoder;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, addr, ack;
  logic [7:0] wdata, rdata, irq_in, vec_out;
  logic       int_req, level_unsup;
  int         n_chk = 0, n_fail = 0;
  logic       done = 1'b0;

  always #10 clk = ~clk;

  pic_cmd_decoder i_pic_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .ack(ack),
    .int_req(int_req), .vec_out(vec_out), .level_unsup(level_unsup)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input int l);
    @(negedge clk); irq_in[l] = 1'b1;
    @(negedge clk); irq_in[l] = 1'b0;
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0; v = vec_out;
  endtask

  task automatic setup(input logic [7:0] mode);
    wr(0, 8'h13); wr(1, 8'h40); wr(1, mode);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 reset int_req", {7'd0, int_req}, 8'h00);
    chk("R1 reset level flag", {7'd0, level_unsup}, 8'h00);
    rd(1, v); chk("R1 reset mask", v, 8'h00);
  endtask

  task automatic t_init();
    logic [7:0] v;
    wr(0, 8'h1B);
    chk("R1 level request flagged", {7'd0, level_unsup}, 8'h01);
    wr(1, 8'h48); wr(1, 8'h00); wr(1, 8'hFF);
    rd(1, v); chk("R2 single+mode sequence then mask", v, 8'hFF);
    wr(0, 8'h11);
    chk("R1 flag cleared by plain init", {7'd0, level_unsup}, 8'h00);
    rd(1, v); chk("R1 mask cleared by init", v, 8'h00);
    wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h02); wr(1, 8'h0F);
    rd(1, v); chk("R2 cascade word consumed", v, 8'h0F);
    wr(1, 8'h00);
    pulse(3);
    chk("R4 request raised", {7'd0, int_req}, 8'h01);
    do_ack(v); chk("R3 vector base+line", v, 8'h23);
    wr(0, 8'h0B); rd(0, v); chk("R5 auto eoi leaves isr empty", v, 8'h00);
    wr(0, 8'h0A); rd(0, v); chk("R5 pending cleared by ack", v, 8'h00);
    wr(0, 8'h12); wr(1, 8'h50); wr(1, 8'hAA);
    rd(1, v); chk("R2 single without mode word", v, 8'hAA);
  endtask

  task automatic t_prio();
    logic [7:0] v;
    setup(8'h00);
    pulse(5); pulse(2);
    rd(0, v); chk("R4 pending register", v, 8'h24);
    do_ack(v); chk("R4 highest rank wins", v, 8'h42);
    chk("R4 blocked by in-service", {7'd0, int_req}, 8'h00);
    do_ack(v); chk("R5 spurious vector", v, 8'h47);
    rd(0, v); chk("R5 spurious leaves pending", v, 8'h20);
    wr(0, 8'h0B); rd(0, v); chk("R5 in-service set", v, 8'h04);
    wr(0, 8'h20); rd(0, v); chk("R7 nonspecific eoi", v, 8'h00);
    chk("R7 request after eoi", {7'd0, int_req}, 8'h01);
    do_ack(v); chk("R7 next vector", v, 8'h45);
    wr(0, 8'hA0); rd(0, v); chk("R7 rotate eoi clears", v, 8'h00);
    pulse(3); pulse(6);
    do_ack(v); chk("R7 offset after rotate", v, 8'h46);
    wr(0, 8'h66); rd(0, v); chk("R8 specific eoi", v, 8'h00);
    do_ack(v); chk("R8 remaining line", v, 8'h43);
    wr(0, 8'hE3); rd(0, v); chk("R8 rotate specific clears", v, 8'h00);
    pulse(2); pulse(5);
    do_ack(v); chk("R8 offset after rotate specific", v, 8'h45);
    wr(0, 8'h65); do_ack(v); wr(0, 8'h62);
    wr(0, 8'hC1); rd(0, v); chk("R9 set priority keeps isr", v, 8'h00);
    pulse(1); pulse(2);
    do_ack(v); chk("R9 offset two", v, 8'h42);
    chk("R9 rank seven blocked", {7'd0, int_req}, 8'h00);
    wr(0, 8'h20);
    wr(0, 8'hA0); rd(0, v); chk("R10 empty eoi isr", v, 8'h00);
    pulse(6);
    do_ack(v); chk("R10 offset unchanged", v, 8'h46);
  endtask

  task automatic t_rotate_auto();
    logic [7:0] v;
    setup(8'h02);
    wr(0, 8'h80);
    pulse(4); do_ack(v); chk("R6 auto ack", v, 8'h44);
    pulse(3); pulse(6);
    do_ack(v); chk("R6 rotated on auto eoi", v, 8'h46);
    wr(0, 8'h00);
    do_ack(v); chk("R6 leftover line", v, 8'h43);
    pulse(0); pulse(6);
    do_ack(v); chk("R6 rotate switched off", v, 8'h40);
  endtask

  task automatic t_read_poll();
    logic [7:0] v;
    setup(8'h00);
    pulse(4);
    wr(0, 8'h09); rd(0, v); chk("R11 select ignored without enable", v, 8'h10);
    wr(0, 8'h0B); rd(0, v); chk("R11 in-service selected", v, 8'h00);
    wr(0, 8'h03); do_ack(v); rd(0, v); chk("R11 in-service after ack", v, 8'h10);
    wr(0, 8'h20);
    pulse(5);
    wr(0, 8'h0C); rd(0, v); chk("R12 poll returns line", v, 8'h85);
    rd(0, v); chk("R12 poll accepted line", v, 8'h20);
    wr(0, 8'h0C); rd(0, v); chk("R12 poll with no request", v, 8'h00);
    rd(0, v); chk("R12 poll cleared", v, 8'h20);
  endtask

  task automatic t_special();
    logic [7:0] v;
    setup(8'h00);
    pulse(2); do_ack(v);
    pulse(5); wr(1, 8'h04);
    chk("R13 blocked without special mask", {7'd0, int_req}, 8'h00);
    wr(0, 8'h68);
    chk("R13 special mask unblocks", {7'd0, int_req}, 8'h01);
    wr(0, 8'h48);
    chk("R13 special mask off", {7'd0, int_req}, 8'h00);
    setup(8'h10);
    pulse(2); do_ack(v);
    pulse(5);
    chk("R14 nested line ignored", {7'd0, int_req}, 8'h01);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 1'b0; ack = 1'b0;
    wdata = '0; irq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init();
    t_prio();
    t_rotate_auto();
    t_read_poll();
    t_special();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule